// File: doc/BRIEF.md
# Keyed Indexed Configuration Window

This block is a byte-wide configuration register file reached through two addresses: an index port and a data port. The index port chooses which register the data port reads or writes. Access is locked after reset. It opens only after the enter key 0x87 is written to the index port on two index writes in a row. The exit key 0xAA, written to the index port, locks it again.

Once open, the index selects either a global register or a banked register. Global registers hold a device identifier, a revision byte, a strap byte and the logical-device select. Each bank's registers start at index 0x30, and the logical-device select chooses which bank appears there. Downstream functions see the current select, one enable bit per bank and every banked byte. Read data is registered and appears on the cycle after the read strobe.

Top module: `cfgw_top`

## Requirements
- R1: After reset the window is locked, the index and logical-device select are 0x00, every bank enable and banked byte is 0x00, and read data is 0x00.
- R2: Two index-port writes of 0x87 with no other index-port write between them open the window. Any other value written to the index port while locked restarts the key count.
- R3: While open, writing 0xAA to the index port locks the window and leaves the index unchanged.
- R4: While locked, data-port writes change nothing, index-port writes do not change the index, and reads at either port return 0xFF.
- R5: While open, an index-port write other than 0xAA loads the index, and an index-port read returns it.
- R6: Index 0x20 reads the parameter DEV_ID and index 0x21 reads DEV_REV. Writes to these two indexes have no effect.
- R7: Index 0x26 reads the base-select strap input in bit 6, with 0 for the lower base and 1 for the upper base. All other bits of this byte read 0.
- R8: Index 0x07 is the logical-device select. It is readable and writable, and it drives ldn_sel.
- R9: Indexes 0x30 to 0x30+NREG-1 reach the bank chosen by the select. Each bank keeps its own bytes, and bank b byte r appears on bank_cfg bits [(b*NREG+r)*8 +: 8]. When the select is NBANK or more, these indexes read 0x00 and writes to them are ignored.
- R10: Bit 0 of index 0x30 in bank b drives bank_en[b].
- R11: Reads of any other index return 0x00 and change nothing. rdata updates only on the cycle after a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_sel | input | 1 | Strap: 0 lower base, 1 upper base |
| addr | input | 1 | 0 index port, 1 data port |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| ldn_sel | output | 8 | Current logical-device select |
| bank_en | output | NBANK | Enable bit per bank |
| bank_cfg | output | NBANK*NREG*8 | All banked bytes, flattened |

## Verification
The assertions assume that rd and wr are never high in the same cycle, that each strobe lasts one cycle, and that base_sel only changes while no read is in progress. The bench drives every access from a task that raises a single strobe for exactly one cycle on the falling edge. It changes the strap only between accesses. The data-port effects it checks are then unambiguous.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
  localparam logic [7:0] KEY_ENTER     = 8'h87;
  localparam logic [7:0] KEY_EXIT      = 8'hAA;
  localparam logic [7:0] IDX_LDN       = 8'h07;
  localparam logic [7:0] IDX_DEVID     = 8'h20;
  localparam logic [7:0] IDX_REV       = 8'h21;
  localparam logic [7:0] IDX_STRAP     = 8'h26;
  localparam logic [7:0] IDX_BANK_BASE = 8'h30;
  localparam logic [7:0] LOCKED_READ   = 8'hFF;

  typedef enum logic [1:0] {
    GATE_LOCKED = 2'd0,
    GATE_HALF   = 2'd1,
    GATE_OPEN   = 2'd2
  } gate_state_e;
endpackage

// File: rtl/cfgw_gate.sv
module cfgw_gate
  import cfgw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       unlocked
);
  gate_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= GATE_LOCKED;
    end else if (idx_wr) begin
      unique case (state_q)
        GATE_LOCKED: state_q <= (wdata == KEY_ENTER) ? GATE_HALF : GATE_LOCKED;
        GATE_HALF:   state_q <= (wdata == KEY_ENTER) ? GATE_OPEN : GATE_LOCKED;
        GATE_OPEN:   state_q <= (wdata == KEY_EXIT)  ? GATE_LOCKED : GATE_OPEN;
        default:     state_q <= GATE_LOCKED;
      endcase
    end
  end

  assign unlocked = (state_q == GATE_OPEN);

  assert_open_needs_key_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(idx_wr && (wdata == KEY_ENTER)));

  assert_exit_relocks_R3: assert property (@(posedge clk) disable iff (rst)
    (unlocked && idx_wr && (wdata == KEY_EXIT)) |=> !unlocked);
endmodule

// File: rtl/cfgw_banks.sv
module cfgw_banks
  import cfgw_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int NREG  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [7:0]              ldn,
  input  logic [7:0]              idx,
  input  logic [7:0]              wdata,
  output logic                    hit,
  output logic [7:0]              rd_byte,
  output logic [NBANK-1:0]        bank_en,
  output logic [NBANK*NREG*8-1:0] bank_cfg
);
  localparam int SLOTS  = NBANK * NREG;
  localparam int SEL_W  = $clog2(NBANK);
  localparam int OFF_W  = $clog2(NREG);
  localparam int FLAT_W = $clog2(SLOTS);

  logic [7:0]        regs [SLOTS];
  logic [7:0]        off8;
  logic [FLAT_W-1:0] flat;

  assign off8 = idx - IDX_BANK_BASE;
  assign hit  = (idx >= IDX_BANK_BASE) && (off8 < 8'(NREG)) && (ldn < 8'(NBANK));
  assign flat = FLAT_W'(ldn[SEL_W-1:0]) * FLAT_W'(NREG) + FLAT_W'(off8[OFF_W-1:0]);
  assign rd_byte = hit ? regs[flat] : 8'h00;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) regs[i] <= 8'h00;
    end else if (we && hit) begin
      regs[flat] <= wdata;
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank_en[b] = regs[b*NREG][0];
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      assign bank_cfg[(b*NREG+r)*8 +: 8] = regs[b*NREG+r];
    end
  end

  assert_out_of_range_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (we && (ldn >= 8'(NBANK))) |=> $stable(bank_cfg));
endmodule

// File: rtl/cfgw_top.sv
module cfgw_top
  import cfgw_pkg::*;
#(
  parameter int         NBANK   = 4,
  parameter int         NREG    = 4,
  parameter logic [7:0] DEV_ID  = 8'h5C,
  parameter logic [7:0] DEV_REV = 8'h21
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    base_sel,
  input  logic                    addr,
  input  logic                    wr,
  input  logic                    rd,
  input  logic [7:0]              wdata,
  output logic [7:0]              rdata,
  output logic [7:0]              ldn_sel,
  output logic [NBANK-1:0]        bank_en,
  output logic [NBANK*NREG*8-1:0] bank_cfg
);
  logic       unlocked;
  logic       idx_wr, dat_wr;
  logic [7:0] idx_q, ldn_q, rdata_q;
  logic       bank_hit;
  logic [7:0] bank_byte, rd_mux;

  assign idx_wr = wr && !addr;
  assign dat_wr = wr && addr && unlocked;

  cfgw_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .idx_wr   (idx_wr),
    .wdata    (wdata),
    .unlocked (unlocked)
  );

  cfgw_banks #(.NBANK(NBANK), .NREG(NREG)) u_banks (
    .clk      (clk),
    .rst      (rst),
    .we       (dat_wr),
    .ldn      (ldn_q),
    .idx      (idx_q),
    .wdata    (wdata),
    .hit      (bank_hit),
    .rd_byte  (bank_byte),
    .bank_en  (bank_en),
    .bank_cfg (bank_cfg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= 8'h00;
      ldn_q <= 8'h00;
    end else begin
      if (idx_wr && unlocked && (wdata != KEY_EXIT)) idx_q <= wdata;
      if (dat_wr && (idx_q == IDX_LDN)) ldn_q <= wdata;
    end
  end

  always_comb begin
    if (!unlocked) begin
      rd_mux = LOCKED_READ;
    end else if (!addr) begin
      rd_mux = idx_q;
    end else begin
      unique case (idx_q)
        IDX_LDN:   rd_mux = ldn_q;
        IDX_DEVID: rd_mux = DEV_ID;
        IDX_REV:   rd_mux = DEV_REV;
        IDX_STRAP: rd_mux = {1'b0, base_sel, 6'b0};
        default:   rd_mux = bank_hit ? bank_byte : 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= 8'h00;
    else if (rd) rdata_q <= rd_mux;
  end

  assign rdata   = rdata_q;
  assign ldn_sel = ldn_q;

  assert_locked_reads_ff_R4: assert property (@(posedge clk) disable iff (rst)
    (rd && !unlocked) |=> (rdata == 8'hFF));

  assert_locked_writes_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (wr && !unlocked) |=> ($stable(bank_cfg) && $stable(ldn_sel)));

  assert_devid_read_R6: assert property (@(posedge clk) disable iff (rst)
    (rd && unlocked && addr && (idx_q == IDX_DEVID)) |=> (rdata == DEV_ID));

  assert_rdata_holds_R11: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));
endmodule

// File: tb/tb_cfgw_top.sv
module tb_cfgw_top;
  localparam int NBANK = 4;
  localparam int NREG  = 4;
  localparam logic [7:0] DEV_ID  = 8'h5C;
  localparam logic [7:0] DEV_REV = 8'h21;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic base_sel = 1'b0;
  logic addr = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata, ldn_sel;
  logic [NBANK-1:0] bank_en;
  logic [NBANK*NREG*8-1:0] bank_cfg;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cfgw_top #(.NBANK(NBANK), .NREG(NREG), .DEV_ID(DEV_ID), .DEV_REV(DEV_REV)) dut (
    .clk(clk), .rst(rst), .base_sel(base_sel), .addr(addr), .wr(wr), .rd(rd),
    .wdata(wdata), .rdata(rdata), .ldn_sel(ldn_sel), .bank_en(bank_en), .bank_cfg(bank_cfg)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic do_rd(input logic a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic unlock();
    do_wr(1'b0, 8'h87);
    do_wr(1'b0, 8'h87);
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
    do_wr(1'b0, i);
    do_wr(1'b1, d);
  endtask

  task automatic reg_rd(input logic [7:0] i, output logic [7:0] d);
    do_wr(1'b0, i);
    do_rd(1'b1, d);
  endtask

  task automatic t_reset_state();
    chk("R1 rdata", 64'(rdata), 64'h00);
    chk("R1 ldn_sel", 64'(ldn_sel), 64'h00);
    chk("R1 bank_en", 64'(bank_en), 64'h0);
    chk("R1 bank_cfg", 64'(bank_cfg), 64'h0);
  endtask

  task automatic t_locked();
    logic [7:0] v;
    do_rd(1'b1, v); chk("R4 locked data read", 64'(v), 64'hFF);
    do_rd(1'b0, v); chk("R4 locked index read", 64'(v), 64'hFF);
    do_wr(1'b1, 8'h03);
    chk("R4 locked data write ignored", 64'(ldn_sel), 64'h00);
    chk("R4 locked write bank untouched", 64'(bank_cfg), 64'h0);
  endtask

  task automatic t_broken_key();
    logic [7:0] v;
    do_wr(1'b0, 8'h87);
    do_wr(1'b0, 8'h11);
    do_wr(1'b0, 8'h87);
    do_rd(1'b0, v); chk("R2 interrupted key stays locked", 64'(v), 64'hFF);
    do_wr(1'b0, 8'h87);
    do_rd(1'b0, v); chk("R2 two keys in a row unlock", 64'(v), 64'h00);
  endtask

  task automatic t_index_globals();
    logic [7:0] v;
    do_wr(1'b0, 8'h5A);
    do_rd(1'b0, v); chk("R5 index readback", 64'(v), 64'h5A);
    reg_rd(8'h20, v); chk("R6 device id", 64'(v), 64'(DEV_ID));
    reg_rd(8'h21, v); chk("R6 revision", 64'(v), 64'(DEV_REV));
    do_wr(1'b1, 8'h00);
    do_rd(1'b1, v); chk("R6 revision is read-only", 64'(v), 64'(DEV_REV));
    reg_rd(8'h26, v); chk("R7 strap low base", 64'(v), 64'h00);
    base_sel = 1'b1;
    do_rd(1'b1, v); chk("R7 strap high base", 64'(v), 64'h40);
    base_sel = 1'b0;
    reg_rd(8'h55, v); chk("R11 unimplemented reads zero", 64'(v), 64'h00);
    @(negedge clk); chk("R11 rdata holds without read", 64'(rdata), 64'h00);
  endtask

  task automatic t_banks();
    logic [7:0] v;
    reg_wr(8'h07, 8'h02);
    chk("R8 ldn_sel output", 64'(ldn_sel), 64'h02);
    do_rd(1'b1, v); chk("R8 ldn readback", 64'(v), 64'h02);
    reg_wr(8'h30, 8'h01);
    chk("R10 bank 2 enabled", 64'(bank_en), 64'h4);
    reg_wr(8'h31, 8'hC3);
    chk("R9 bank 2 byte 1 position", 64'(bank_cfg[(2*NREG+1)*8 +: 8]), 64'hC3);
    reg_wr(8'h07, 8'h01);
    reg_rd(8'h30, v); chk("R9 bank 1 separate", 64'(v), 64'h00);
    reg_wr(8'h30, 8'hFF);
    chk("R10 bank 1 and 2 enabled", 64'(bank_en), 64'h6);
    reg_wr(8'h07, 8'h02);
    reg_rd(8'h31, v); chk("R9 bank 2 byte kept", 64'(v), 64'hC3);
    reg_wr(8'h07, 8'h07);
    reg_wr(8'h30, 8'h01);
    chk("R9 out-of-range bank write ignored", 64'(bank_en), 64'h6);
    do_rd(1'b1, v); chk("R9 out-of-range bank reads zero", 64'(v), 64'h00);
    reg_rd(8'h34, v); chk("R11 beyond last banked index", 64'(v), 64'h00);
  endtask

  task automatic t_exit();
    logic [7:0] v;
    do_wr(1'b0, 8'h21);
    do_wr(1'b0, 8'hAA);
    do_rd(1'b1, v); chk("R3 exit key relocks", 64'(v), 64'hFF);
    unlock();
    do_rd(1'b0, v); chk("R3 index unchanged by exit key", 64'(v), 64'h21);
    do_wr(1'b0, 8'hAA);
    do_wr(1'b0, 8'h30);
    unlock();
    do_rd(1'b0, v); chk("R4 locked index write not loaded", 64'(v), 64'h21);
  endtask

  task automatic t_reset_again();
    do_reset();
    chk("R1 reset clears enables", 64'(bank_en), 64'h0);
    chk("R1 reset clears ldn", 64'(ldn_sel), 64'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_locked();
    t_broken_key();
    t_index_globals();
    t_banks();
    t_exit();
    t_reset_again();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule